// File: doc/BRIEF.md
# Card Status Change Interrupt Unit

This block watches one removable-card socket. Seven socket pins are resynchronised and debounced: two card-detect pins, two battery-voltage-detect pins, write protect, ready/busy and power good. The block keeps the clean copy as a live status byte. When the card is inserted or removed, when the battery code enters the warning or dead state, or when ready/busy toggles, it sets a sticky change bit. Any change bit whose enable bit is set raises an interrupt request. The request goes out together with a 4-bit interrupt line number that software has programmed.

Software reaches the block through a two-location port. Location 0 holds an 8-bit register index. Location 1 reads or writes the byte register that the index selects. A read returns its data on `bus_rdata` one clock after the read strobe. The block also holds the socket's power control byte, which drives three enable outputs towards the external power switch. All pins are plain level or strobe signals, so the port has no back-pressure: every strobe is taken in the cycle it is presented.

Top module: `csc_socket_unit`

## Requirements
- R1: A write to location 0 loads the index register and a read of location 0 returns it. Data accesses at location 1 go to the register the index selects. At an index with no register, a read returns 0x00 and a write changes nothing.
- R2: The status byte at index 0x01 returns the debounced pins: bits 1:0 are the battery pins, bits 3:2 the detect pins, bit 4 write protect, bit 5 ready/busy, bit 6 power good, and bit 7 reads 0.
- R3: Change bit 3 at index 0x04 is set when card presence toggles. The card counts as present only while both detect pins read 1. A change on one detect pin that leaves presence unchanged sets nothing.
- R4: Change bit 1 is set when the battery code enters warning (2'b10). Change bit 0 is set when it enters dead (bit 1 of the code is 0). Entering good (2'b11), or moving from one dead code to the other, sets nothing.
- R5: Change bit 2 is set on every toggle of the debounced ready/busy pin.
- R6: A read of index 0x04 returns the latched change bits in bits 3:0, with 0 in bits 7:4, and clears them in the same access. An event detected in that same cycle stays latched.
- R7: `irq_req` is high exactly while some change bit is set and bit n of the configuration byte at index 0x05 is also set, where n is the position of that change bit. `irq_num` equals bits 7:4 of that byte.
- R8: The power byte at index 0x02 keeps bits 7, 5 and 4 and reads the other bits as 0. These bits drive `out_en`, `auto_pwr` and `card_en` in that order. Writing 0 to it turns all three off.
- R9: A pin level that holds for fewer than DEB_CYCLES consecutive clocks after synchronisation does not reach the status byte and sets no change bit.
- R10: Reset clears the index, the change bits, the configuration and power bytes and the debounced pin state, and holds `irq_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_pin | input | 2 | Card-detect pins, 1 = asserted |
| bvd_pin | input | 2 | Battery voltage detect pins |
| wp_pin | input | 1 | Write protect pin |
| rdy_pin | input | 1 | Ready/busy pin |
| pwr_good | input | 1 | Card power good indication |
| bus_addr | input | 1 | 0 = index location, 1 = data location |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after the read strobe |
| irq_req | output | 1 | Status-change interrupt request |
| irq_num | output | 4 | Selected interrupt line number |
| out_en | output | 1 | Socket output enable |
| auto_pwr | output | 1 | Automatic power switching enable |
| card_en | output | 1 | Card enable |

## Verification
The detect pins are driven with a one-pin change and then a both-pin change. This separates a true presence toggle from a partial contact. The battery pins step through good, warning, both dead codes and back to good, which shows that only entry into warning or dead is latched. The ready pin is toggled with its enable off and later with a short glitch, which separates a latched but masked event from a filtered one. Clear-on-read is checked against the interrupt request, and the power byte is written with all ones and then with zero.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam logic [7:0] IDX_STATUS = 8'h01;
  localparam logic [7:0] IDX_POWER  = 8'h02;
  localparam logic [7:0] IDX_CHANGE = 8'h04;
  localparam logic [7:0] IDX_CONFIG = 8'h05;

  localparam int CHG_DET  = 3;
  localparam int CHG_RDY  = 2;
  localparam int CHG_WARN = 1;
  localparam int CHG_DEAD = 0;
  localparam int CHG_W    = 4;

  localparam logic [7:0] POWER_MASK = 8'hB0;

  typedef struct packed {
    logic       pwr;
    logic       rdy;
    logic       wp;
    logic [1:0] det;
    logic [1:0] bvd;
  } sock_pins_t;

  localparam int PIN_W = $bits(sock_pins_t);
endpackage

// File: rtl/csc_debounce.sv
module csc_debounce #(
  parameter int N           = 7,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] clean
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [SYNC_STAGES-1:0] sh;
    logic [CW-1:0]          cnt;
    logic                   settled;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh      <= '0;
        cnt     <= '0;
        settled <= 1'b0;
      end else begin
        sh <= {sh[SYNC_STAGES-2:0], raw[i]};
        if (sh[SYNC_STAGES-1] == settled) begin
          cnt <= '0;
        end else if (cnt == CW'(DEB_CYCLES - 1)) begin
          settled <= sh[SYNC_STAGES-1];
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign clean[i] = settled;
  end
endmodule

// File: rtl/csc_events.sv
module csc_events
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  sock_pins_t        cur,
  output logic [CHG_W-1:0]  ev
);
  sock_pins_t prev;
  logic now_present, was_present;
  logic now_warn, was_warn, now_dead, was_dead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

  always_comb begin
    now_present = &cur.det;
    was_present = &prev.det;
    now_warn    = (cur.bvd == 2'b10);
    was_warn    = (prev.bvd == 2'b10);
    now_dead    = ~cur.bvd[1];
    was_dead    = ~prev.bvd[1];
    ev           = '0;
    ev[CHG_DET]  = now_present ^ was_present;
    ev[CHG_RDY]  = cur.rdy ^ prev.rdy;
    ev[CHG_WARN] = now_warn & ~was_warn;
    ev[CHG_DEAD] = now_dead & ~was_dead;
  end
endmodule

// File: rtl/csc_change_latch.sv
module csc_change_latch
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CHG_W-1:0] ev,
  input  logic             clr,
  output logic [CHG_W-1:0] chg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg <= '0;
    else        chg <= (chg & {CHG_W{~clr}}) | ev;
  end
endmodule

// File: rtl/csc_regs.sv
module csc_regs
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  input  sock_pins_t       pins,
  input  logic [CHG_W-1:0] chg,
  output logic [7:0]       rdata,
  output logic [7:0]       idx,
  output logic [7:0]       cfg,
  output logic [7:0]       pwr,
  output logic             chg_clr
);
  logic [7:0] sel_val;
  logic       data_wr;

  assign data_wr = bus_wr & bus_addr;
  assign chg_clr = bus_rd & bus_addr & (idx == IDX_CHANGE);

  always_comb begin
    case (idx)
      IDX_STATUS: sel_val = {1'b0, pins};
      IDX_POWER:  sel_val = pwr;
      IDX_CHANGE: sel_val = {{(8-CHG_W){1'b0}}, chg};
      IDX_CONFIG: sel_val = cfg;
      default:    sel_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      cfg   <= '0;
      pwr   <= '0;
      rdata <= '0;
    end else begin
      if (bus_wr && !bus_addr) idx <= bus_wdata;
      if (data_wr && idx == IDX_POWER)  pwr <= bus_wdata & POWER_MASK;
      if (data_wr && idx == IDX_CONFIG) cfg <= bus_wdata;
      if (bus_rd) rdata <= bus_addr ? sel_val : idx;
    end
  end
endmodule

// File: rtl/csc_socket_unit.sv
module csc_socket_unit
  import csc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] det_pin,
  input  logic [1:0] bvd_pin,
  input  logic       wp_pin,
  input  logic       rdy_pin,
  input  logic       pwr_good,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_req,
  output logic [3:0] irq_num,
  output logic       out_en,
  output logic       auto_pwr,
  output logic       card_en
);
  sock_pins_t       raw_pins, clean_pins;
  logic [CHG_W-1:0] ev_vec, chg_q;
  logic [7:0]       idx_q, cfg_q, pwr_q;
  logic             chg_clr;

  always_comb begin
    raw_pins.pwr = pwr_good;
    raw_pins.rdy = rdy_pin;
    raw_pins.wp  = wp_pin;
    raw_pins.det = det_pin;
    raw_pins.bvd = bvd_pin;
  end

  csc_debounce #(.N(PIN_W), .SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw(raw_pins), .clean(clean_pins)
  );

  csc_events u_ev (.clk(clk), .rst_n(rst_n), .cur(clean_pins), .ev(ev_vec));

  csc_change_latch u_latch (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr(chg_clr), .chg(chg_q)
  );

  csc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .pins(clean_pins), .chg(chg_q), .rdata(bus_rdata),
    .idx(idx_q), .cfg(cfg_q), .pwr(pwr_q), .chg_clr(chg_clr)
  );

  assign irq_req  = |(chg_q & cfg_q[CHG_W-1:0]);
  assign irq_num  = cfg_q[7:4];
  assign out_en   = pwr_q[7];
  assign auto_pwr = pwr_q[5];
  assign card_en  = pwr_q[4];
endmodule

// File: rtl/csc_socket_unit_chk.sv
module csc_socket_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] idx,
  input logic [3:0] chg,
  input logic [3:0] ev,
  input logic [7:0] cfg,
  input logic [6:0] status,
  input logic       irq_req,
  input logic [3:0] irq_num,
  input logic       out_en,
  input logic       auto_pwr,
  input logic       card_en
);
  // R7: no request unless some enable is set
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cfg[3:0] != 4'h0));

  // R7: line number moves only after a data write
  p_irqnum_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_num) |-> $past(bus_wr && bus_addr));

  // R3: presence toggle is latched
  p_det_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev[3] |=> chg[3]);

  // R6: read with no new event empties the latch
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr && idx == 8'h04 && ev == 4'h0) |=> (chg == 4'h0));

  // R8: writing zero removes all power enables
  p_power_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && idx == 8'h02 && bus_wdata == 8'h00) |=> !(out_en || auto_pwr || card_en));

  // R9: a debounced bit cannot change on two consecutive clocks
  for (genvar i = 0; i < 7; i++) begin : g_deb
    p_deb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status[i]) |=> $stable(status[i]));
  end

  // R10: reset holds the latch empty and the request low
  always_ff @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r10: assert (chg == 4'h0 && !irq_req);
    end
  end
endmodule

bind csc_socket_unit csc_socket_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .idx(idx_q), .chg(chg_q), .ev(ev_vec), .cfg(cfg_q),
  .status(clean_pins), .irq_req(irq_req), .irq_num(irq_num), .out_en(out_en),
  .auto_pwr(auto_pwr), .card_en(card_en)
);

// File: tb/csc_socket_unit_bench.sv
module csc_socket_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] det_pin = 2'b00;
  logic [1:0] bvd_pin = 2'b00;
  logic       wp_pin = 1'b0;
  logic       rdy_pin = 1'b0;
  logic       pwr_good = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_req;
  logic [3:0] irq_num;
  logic       out_en, auto_pwr, card_en;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  csc_socket_unit u_csc_socket_unit (
    .clk(clk), .rst_n(rst_n), .det_pin(det_pin), .bvd_pin(bvd_pin), .wp_pin(wp_pin),
    .rdy_pin(rdy_pin), .pwr_good(pwr_good), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_num(irq_num), .out_en(out_en), .auto_pwr(auto_pwr), .card_en(card_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic loc, input logic [7:0] v);
    @(negedge clk);
    bus_addr = loc; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic loc, output logic [7:0] v);
    @(negedge clk);
    bus_addr = loc; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic reg_rd(input logic [7:0] index, output logic [7:0] v);
    bus_write(1'b0, index);
    bus_read(1'b1, v);
  endtask

  task automatic reg_wr(input logic [7:0] index, input logic [7:0] v);
    bus_write(1'b0, index);
    bus_write(1'b1, v);
  endtask

  task automatic settle();
    repeat (24) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R10 irq_req", int'(irq_req), 0);
    check("R10 power outputs", int'({out_en, auto_pwr, card_en}), 0);
    bus_read(1'b0, v);
    check("R10 index", v, 0);
    reg_rd(8'h05, v);
    check("R10 config", v, 0);
    reg_rd(8'h04, v);
    check("R10 change", v, 0);
  endtask

  task automatic t_index();
    logic [7:0] v;
    bus_write(1'b0, 8'h33);
    bus_read(1'b0, v);
    check("R1 index readback", v, 8'h33);
    bus_write(1'b1, 8'hFF);
    bus_read(1'b1, v);
    check("R1 unmapped read", v, 8'h00);
    reg_rd(8'h05, v);
    check("R1 unmapped write no effect", v, 8'h00);
  endtask

  task automatic t_power();
    logic [7:0] v;
    reg_wr(8'h02, 8'hFF);
    check("R8 outputs on", int'({out_en, auto_pwr, card_en}), 7);
    bus_read(1'b1, v);
    check("R8 readback mask", v, 8'hB0);
    bus_write(1'b1, 8'h00);
    check("R8 outputs off", int'({out_en, auto_pwr, card_en}), 0);
  endtask

  task automatic t_status_battery();
    logic [7:0] v;
    @(negedge clk); bvd_pin = 2'b11; wp_pin = 1'b1; pwr_good = 1'b1;
    settle();
    reg_rd(8'h01, v);
    check("R2 status byte", v, 8'h53);
    reg_rd(8'h04, v);
    check("R4 good sets nothing", v, 8'h00);
    @(negedge clk); bvd_pin = 2'b10; settle();
    reg_rd(8'h04, v);
    check("R4 warning", v, 8'h02);
    @(negedge clk); bvd_pin = 2'b00; settle();
    reg_rd(8'h04, v);
    check("R4 dead", v, 8'h01);
    @(negedge clk); bvd_pin = 2'b01; settle();
    reg_rd(8'h04, v);
    check("R4 dead to dead", v, 8'h00);
    @(negedge clk); bvd_pin = 2'b11; settle();
    reg_rd(8'h04, v);
    check("R4 back to good", v, 8'h00);
  endtask

  task automatic t_ready_masked();
    logic [7:0] v;
    @(negedge clk); rdy_pin = 1'b1; settle();
    check("R7 masked no irq", int'(irq_req), 0);
    reg_rd(8'h04, v);
    check("R5 ready toggle", v, 8'h04);
  endtask

  task automatic t_detect_irq();
    logic [7:0] v;
    reg_wr(8'h05, 8'h58);
    check("R7 irq_num", int'(irq_num), 5);
    @(negedge clk); det_pin = 2'b01; settle();
    check("R3 partial no irq", int'(irq_req), 0);
    reg_rd(8'h04, v);
    check("R3 partial contact", v, 8'h00);
    @(negedge clk); det_pin = 2'b11; settle();
    check("R7 irq raised", int'(irq_req), 1);
    reg_rd(8'h04, v);
    check("R6 read returns", v, 8'h08);
    check("R6 read clears irq", int'(irq_req), 0);
    reg_rd(8'h04, v);
    check("R6 cleared", v, 8'h00);
    @(negedge clk); det_pin = 2'b10; settle();
    check("R3 removal irq", int'(irq_req), 1);
    reg_rd(8'h04, v);
    check("R3 removal", v, 8'h08);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    reg_rd(8'h01, v);
    check("R9 status before", v, 8'h7B);
    @(negedge clk); rdy_pin = 1'b0;
    repeat (3) @(negedge clk);
    rdy_pin = 1'b1;
    settle();
    reg_rd(8'h01, v);
    check("R9 status after glitch", v, 8'h7B);
    reg_rd(8'h04, v);
    check("R9 no change latched", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_power();
    t_status_battery();
    t_ready_masked();
    t_detect_irq();
    t_glitch();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule